// File: doc/BRIEF.md
# Ordered Key Register Loader

This block collects a cipher key that software writes one 32-bit word at a time into eight word slots, and it only declares the key usable when the words arrived in a strict order. For a 128-bit key the slots 0 to 3 are used; for a 256-bit key all eight slots are used. Software may fill the slots upward, starting at slot 0, or downward, starting at the top slot of the chosen size. Every other order is rejected.

A rejected write raises a sticky key-error flag. While that flag stands, no sequence can make the key valid. Software clears the flag with a one-cycle pulse. A key-selection change strobe wipes every slot to zero at once and drops the valid flag. An external error input lets a neighbouring checker abort the load. All outputs are registered and change on the clock edge that samples the stimulus.

In the register space that drives this block, slots 0 to 3 decode from byte offsets 0x10 to 0x1C and slots 4 to 7 from 0x30 to 0x3C. The decoder turns those offsets into the slot index port.

Top module: `okl_loader`

## Requirements
- R1: After a synchronous reset, every key slot reads zero, and `key_valid` and `key_err` are 0.
- R2: With `key_size`=0, writes to slots 0,1,2,3 in that order store each data word in its slot. Slot i appears at `key_out[32*i +: 32]`. `key_valid` rises on the edge that takes the fourth write, provided `key_err` was 0.
- R3: The descending order (top slot down to 0) is accepted like the ascending one. With `key_size`=1, eight writes in either order (0..7 or 7..0) set `key_valid`.
- R4: If the first write of a sequence targets a slot other than 0 or the top slot, that write is rejected. On a rejected write, `key_err` becomes 1, `key_valid` becomes 0 and the slot keeps its old contents.
- R5: Within a sequence, a write to any slot other than the next one in the chosen direction is rejected as in R4. The sequence then ends, so a later write to slot 0 or to the top slot starts a new one.
- R6: With `key_size`=0, a write to slots 4 to 7 is rejected as in R4.
- R7: While `key_err` is 1, a complete legal sequence stores its words but leaves `key_valid` at 0. After a `err_clr` pulse, a complete legal sequence sets `key_valid`.
- R8: A `sel_change` pulse zeroes all eight slots, clears `key_valid` and ends any sequence on the next edge. `key_err` is unchanged. A write in the same cycle is discarded and causes no error.
- R9: An `ext_err` pulse sets `key_err`, clears `key_valid` and ends any sequence. A write in the same cycle is discarded.
- R10: When an error source (a rejected write or `ext_err`) and `err_clr` occur in the same cycle, `key_err` ends at 1.
- R11: An accepted write that does not complete a sequence clears `key_valid`. After `key_valid` is set, a write to slot 0 or to the top slot starts a new sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Key slot write strobe |
| wr_idx | input | 3 | Slot index of the write |
| wr_data | input | 32 | Word to store |
| key_size | input | 1 | 0 selects 128-bit (4 slots), 1 selects 256-bit (8 slots) |
| sel_change | input | 1 | Key-selection change strobe: erases the key |
| err_clr | input | 1 | Pulse that clears the key-error flag |
| ext_err | input | 1 | External key error input |
| key_out | output | 256 | All slots, slot i at bits 32*i+31 down to 32*i |
| key_valid | output | 1 | Complete key loaded in legal order |
| key_err | output | 1 | Sticky key-error flag |

## Verification
Two pairs of events can land in the same cycle. A write can meet an erase (`sel_change`), and an error source can meet an error clear. The random phase issues strobes of `sel_change`, `ext_err` and `err_clr` on top of write traffic that mostly follows the legal order. The directed part forces each collision on purpose. A bench model built from the requirements predicts the result: the erase drops the write without raising an error, and the error set overrides the clear. The slot vector and both flags are compared after every edge.

// File: rtl/okl_pkg.sv
package okl_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } okl_dir_e;

    typedef struct packed {
        logic     active;
        okl_dir_e dir;
    } okl_seq_t;

    typedef struct packed {
        logic take;
        logic bad;
        logic last;
    } okl_verdict_t;

    function automatic int unsigned okl_span(input logic wide, input int unsigned max_words);
        return wide ? max_words : (max_words / 2);
    endfunction

endpackage

// File: rtl/okl_order_track.sv
module okl_order_track
    import okl_pkg::*;
#(
    parameter int unsigned MAX_WORDS = 8,
    parameter int unsigned IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             key_size,
    input  logic             abort,
    output okl_verdict_t     verdict
);
    localparam int unsigned CMP_W = IDX_W + 1;

    okl_seq_t         seq_q, seq_d;
    logic [IDX_W-1:0] next_q, next_d;
    logic [CMP_W-1:0] span;
    logic [IDX_W-1:0] top;
    okl_dir_e         dir_use;

    always_comb begin
        span    = CMP_W'(okl_span(key_size, MAX_WORDS));
        top     = IDX_W'(span - 1'b1);
        verdict = '0;
        dir_use = seq_q.dir;
        if (wr_go) begin
            if ({1'b0, wr_idx} >= span) begin
                verdict.bad = 1'b1;
            end else if (!seq_q.active) begin
                if (wr_idx == '0) begin
                    verdict.take = 1'b1;
                    dir_use      = DIR_UP;
                end else if (wr_idx == top) begin
                    verdict.take = 1'b1;
                    dir_use      = DIR_DOWN;
                end else begin
                    verdict.bad = 1'b1;
                end
            end else if (wr_idx == next_q) begin
                verdict.take = 1'b1;
            end else begin
                verdict.bad = 1'b1;
            end
            if (verdict.take) begin
                verdict.last = (dir_use == DIR_UP) ? (wr_idx == top) : (wr_idx == '0);
            end
        end
    end

    always_comb begin
        seq_d  = seq_q;
        next_d = next_q;
        if (abort || verdict.bad || verdict.last) begin
            seq_d.active = 1'b0;
        end else if (verdict.take) begin
            seq_d.active = 1'b1;
            seq_d.dir    = dir_use;
            next_d       = (dir_use == DIR_UP) ? wr_idx + 1'b1 : wr_idx - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= '{active: 1'b0, dir: DIR_UP};
            next_q <= '0;
        end else begin
            seq_q  <= seq_d;
            next_q <= next_d;
        end
    end

    AST_VERDICT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(verdict.take && verdict.bad)) else $error("take and bad together"); // R5

endmodule

// File: rtl/okl_word_bank.sv
module okl_word_bank #(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned MAX_WORDS = 8,
    parameter int unsigned IDX_W     = $clog2(MAX_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        erase,
    input  logic                        we,
    input  logic [IDX_W-1:0]            widx,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W*MAX_WORDS-1:0] key_flat
);
    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || erase) begin
                slot_q <= '0;
            end else if (we && (widx == IDX_W'(g))) begin
                slot_q <= wdata;
            end
        end
        assign key_flat[g*WORD_W +: WORD_W] = slot_q;
    end

    AST_ERASE_ZEROES: assert property (@(posedge clk) disable iff (rst)
        erase |=> (key_flat == '0)) else $error("erase left data"); // R8

endmodule

// File: rtl/okl_status.sv
module okl_status
    import okl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         erase,
    input  logic         ext_err,
    input  logic         err_clr,
    input  okl_verdict_t verdict,
    output logic         key_valid,
    output logic         key_err
);
    logic valid_d, err_d;

    always_comb begin
        valid_d = key_valid;
        if (erase || ext_err || verdict.bad) begin
            valid_d = 1'b0;
        end else if (verdict.take) begin
            valid_d = verdict.last && !key_err;
        end
        err_d = key_err;
        if (verdict.bad || ext_err) begin
            err_d = 1'b1;
        end else if (err_clr) begin
            err_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            key_valid <= 1'b0;
            key_err   <= 1'b0;
        end else begin
            key_valid <= valid_d;
            key_err   <= err_d;
        end
    end

    AST_ERR_BLOCKS_VALID: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(!key_err)) else $error("valid rose under error"); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ext_err && err_clr) |=> key_err) else $error("clear won over set"); // R10

endmodule

// File: rtl/okl_loader.sv
module okl_loader
    import okl_pkg::*;
#(
    parameter int unsigned WORD_W    = 32,
    parameter int unsigned MAX_WORDS = 8,
    parameter int unsigned IDX_W     = $clog2(MAX_WORDS),
    parameter int unsigned KEY_W     = WORD_W * MAX_WORDS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              key_size,
    input  logic              sel_change,
    input  logic              err_clr,
    input  logic              ext_err,
    output logic [KEY_W-1:0]  key_out,
    output logic              key_valid,
    output logic              key_err
);
    logic         abort;
    logic         wr_go;
    okl_verdict_t verdict;

    assign abort = sel_change || ext_err;
    assign wr_go = wr_en && !abort;

    okl_order_track #(.MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .wr_idx   (wr_idx),
        .key_size (key_size),
        .abort    (abort),
        .verdict  (verdict)
    );

    okl_word_bank #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .erase    (sel_change),
        .we       (verdict.take),
        .widx     (wr_idx),
        .wdata    (wr_data),
        .key_flat (key_out)
    );

    okl_status u_status (
        .clk       (clk),
        .rst       (rst),
        .erase     (sel_change),
        .ext_err   (ext_err),
        .err_clr   (err_clr),
        .verdict   (verdict),
        .key_valid (key_valid),
        .key_err   (key_err)
    );

    AST_EXT_ERR_EFFECT: assert property (@(posedge clk) disable iff (rst)
        ext_err |=> (key_err && !key_valid)) else $error("ext error ignored"); // R9
    AST_VALID_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(key_valid) |-> $past(wr_en)) else $error("valid without write"); // R2
    AST_SEL_DROPS_VALID: assert property (@(posedge clk) disable iff (rst)
        sel_change |=> !key_valid) else $error("valid survived erase"); // R8

endmodule

// File: tb/okl_loader_tb.sv
module okl_loader_tb;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en, key_size, sel_change, err_clr, ext_err;
    logic [2:0]   wr_idx;
    logic [31:0]  wr_data;
    logic [255:0] key_out;
    logic         key_valid, key_err;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_key [8];
    bit          m_valid, m_err, m_act, m_down;
    int          m_next;

    always #(CLK_P/2) clk = ~clk;

    okl_loader u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .key_size(key_size), .sel_change(sel_change), .err_clr(err_clr), .ext_err(ext_err),
        .key_out(key_out), .key_valid(key_valid), .key_err(key_err)
    );

    function automatic logic [255:0] exp_vec();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = m_key[i];
        return v;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_key[i] = '0;
        m_valid = 0; m_err = 0; m_act = 0; m_down = 0; m_next = 0;
    endtask

    task automatic model_step(input bit we, input int idx, input logic [31:0] d,
                              input bit ks, input bit sc, input bit ec, input bit xe);
        int cnt;
        bit take, nok, last, dn;
        cnt = ks ? 8 : 4;
        take = 0; nok = 0; last = 0; dn = m_down;
        if (we && !sc && !xe) begin
            if (idx >= cnt) nok = 1;
            else if (!m_act) begin
                if (idx == 0) begin take = 1; dn = 0; end
                else if (idx == cnt - 1) begin take = 1; dn = 1; end
                else nok = 1;
            end else if (idx == m_next) take = 1;
            else nok = 1;
            if (take) last = dn ? (idx == 0) : (idx == cnt - 1);
        end
        if (sc) for (int i = 0; i < 8; i++) m_key[i] = '0;
        else if (take) m_key[idx] = d;
        if (sc || xe || nok) m_valid = 0;
        else if (take) m_valid = last && !m_err;
        if (nok || xe) m_err = 1;
        else if (ec) m_err = 0;
        if (sc || xe || nok || last) m_act = 0;
        else if (take) begin
            m_act = 1; m_down = dn; m_next = dn ? idx - 1 : idx + 1;
        end
    endtask

    task automatic check_all(input string tag);
        total++;
        if (key_valid !== m_valid) begin
            bad++; $display("FAIL %s key_valid act=%b exp=%b", tag, key_valid, m_valid);
        end
        total++;
        if (key_err !== m_err) begin
            bad++; $display("FAIL %s key_err act=%b exp=%b", tag, key_err, m_err);
        end
        total++;
        if (key_out !== exp_vec()) begin
            bad++; $display("FAIL %s key_out act=%h exp=%h", tag, key_out, exp_vec());
        end
    endtask

    task automatic step(input bit we, input int idx, input logic [31:0] d, input bit ks,
                        input bit sc, input bit ec, input bit xe, input string tag);
        @(negedge clk);
        wr_en = we; wr_idx = idx[2:0]; wr_data = d; key_size = ks;
        sel_change = sc; err_clr = ec; ext_err = xe;
        @(posedge clk);
        #1;
        model_step(we, idx, d, ks, sc, ec, xe);
        check_all(tag);
    endtask

    task automatic wr(input int idx, input bit ks, input string tag);
        step(1, idx, $urandom, ks, 0, 0, 0, tag);
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++; $display("FAIL %s act=%b exp=%b", tag, act, exp);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; wr_en = 0; wr_idx = 0; wr_data = 0; key_size = 0;
        sel_change = 0; err_clr = 0; ext_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        model_reset();
        step(0, 0, 0, 0, 0, 0, 0, "R1 reset state");

        for (int i = 0; i < 4; i++) wr(i, 0, "R2 ascending 128");
        expect_bit(key_valid, 1'b1, "R2 valid after 4 up");
        for (int i = 3; i >= 0; i--) wr(i, 0, "R11 restart from top");
        expect_bit(key_valid, 1'b1, "R3 valid after 4 down");
        wr(0, 0, "R11 partial write clears valid");
        expect_bit(key_valid, 1'b0, "R11 valid dropped");
        step(1, 0, 32'h0, 0, 1, 0, 0, "R8 erase with write");
        expect_bit(key_err, 1'b0, "R8 no error from discarded write");
        for (int i = 7; i >= 0; i--) wr(i, 1, "R3 descending 256");
        for (int i = 0; i < 8; i++) wr(i, 1, "R3 ascending 256");
        wr(2, 0, "R4 bad first slot");
        expect_bit(key_err, 1'b1, "R4 error set");
        for (int i = 0; i < 4; i++) wr(i, 0, "R7 sequence under error");
        expect_bit(key_valid, 1'b0, "R7 valid blocked");
        step(0, 0, 0, 0, 0, 1, 0, "R7 clear error");
        for (int i = 0; i < 4; i++) wr(i, 0, "R7 sequence after clear");
        expect_bit(key_valid, 1'b1, "R7 valid after clear");
        wr(0, 1, "R5 start"); wr(1, 1, "R5 next"); wr(3, 1, "R5 skip");
        step(0, 0, 0, 0, 0, 1, 0, "R5 clear");
        wr(7, 1, "R5 new seq from top"); wr(6, 1, "R5 continue");
        wr(5, 0, "R6 slot above 128 span");
        expect_bit(key_err, 1'b1, "R6 error set");
        step(1, 0, 32'h1234, 0, 0, 1, 1, "R10 ext error with clear");
        expect_bit(key_err, 1'b1, "R10 set wins");
        step(0, 0, 0, 0, 0, 1, 0, "R10 clear");
        step(1, 0, 32'hdead, 0, 0, 1, 0, "R10 clear then start");
        step(1, 2, 32'hbeef, 0, 0, 1, 0, "R10 bad write with clear");
        expect_bit(key_err, 1'b1, "R10 bad write wins");
        step(1, 0, 32'h5555, 0, 0, 0, 1, "R9 ext error drops write");
        step(0, 0, 0, 0, 1, 0, 0, "R8 erase keeps error");

        for (int n = 0; n < 20000; n++) begin
            bit ks, sc, ec, xe;
            int idx;
            ks  = (n / 500) % 2 == 1;
            sc  = ($urandom % 40) == 0;
            ec  = ($urandom % 10) == 0;
            xe  = ($urandom % 60) == 0;
            if (($urandom % 8) != 0) begin
                if (m_act) idx = m_next;
                else idx = ($urandom % 2) ? 0 : (ks ? 7 : 3);
            end else idx = $urandom % 8;
            step(($urandom % 4) != 0, idx, $urandom, ks, sc, ec, xe, "R5 random mix");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule